// File: doc/BRIEF.md
# Broadcast Neuron Array for a Two-Stage Fixed-Point Network

This block evaluates a small feed-forward network with one hidden layer and one output neuron. A row of identical processing nodes shares one 8-bit activation bus. In every working cycle, each node multiplies the value on that bus by a 16-bit weight from its own weight store and adds the product to its own 32-bit accumulator. Before a run, the host fills the weight stores through a write port. It then pulses `start` and streams the network inputs one per accepted beat.

When the last input has been taken, every accumulator is scaled down by a fixed right shift and clamped to the signed 8-bit range. The result is held as that node's hidden activation. The hidden activations then go back onto the shared bus one node per cycle. All nodes accumulate them again, and node 0 holds the output neuron. Its scaled and clamped sum goes to the 8-bit result port, and `done` pulses for one cycle.

Top module: `nn_mac_array`

## Requirements
- R1: After reset, `done` is 0 and `out_data` is 0.
- R2: A write with `w_we` high stores `w_data` as the weight of node `w_node` at slot `w_addr`. Slots 0 to N_IN-1 weigh the network inputs in arrival order. Slot N_IN+k weighs hidden activation k.
- R3: After `start`, node n accumulates the signed sum of x_k·w[n][k] over exactly N_IN beats. A beat is a cycle with `in_valid` high. Cycles with `in_valid` low neither add nor advance the input count.
- R4: The hidden activation of node n is h_n = clamp(acc_n >>> SHIFT) to the range -128 to 127, taken as a signed arithmetic shift.
- R5: The result is clamp((Σ_k h_k·w[0][N_IN+k]) >>> SHIFT) over all N_NODES hidden activations. It uses the same clamp range as R4.
- R6: `done` is high for exactly one cycle per run. `out_data` changes only on the edge that raises `done` and holds its value afterwards.
- R7: `start` has no effect while a run is in progress. The run in progress completes with the result it would have had without the extra pulse, and no extra `done` follows.
- R8: `in_valid` beats presented before `start` are ignored.
- R9: `done` is observed high after the (N_NODES+2)-th rising edge that follows the edge taking the last input beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| w_we | input | 1 | Weight write enable |
| w_node | input | $clog2(N_NODES) | Node receiving the weight |
| w_addr | input | $clog2(N_IN+N_NODES) | Weight slot within the node |
| w_data | input | 16 | Signed weight value |
| start | input | 1 | Begin a run (taken only when idle) |
| in_valid | input | 1 | Input beat qualifier |
| in_data | input | 8 | Signed network input |
| done | output | 1 | One-cycle result strobe |
| out_data | output | 8 | Signed clamped output neuron value |

## Verification
The bench uses the default build: eight nodes, sixteen inputs and a shift of eight. With these values the input phase is twice as long as the feedback phase, so a mix-up between input slots and feedback slots changes the result. Weights of 256 act as unity gain, so a diagonal pattern gives hand-checkable sums. Full-scale weights drive both clamp limits in the hidden and output stages. Random signed patterns, gapped input beats, stray `start` pulses in both phases, and idle-time beats are each scored against an integer model.

// File: rtl/nn_pkg.sv
package nn_pkg;
  localparam int IN_W  = 8;
  localparam int W_W   = 16;
  localparam int ACC_W = 32;

  typedef logic signed [IN_W-1:0]  act_t;
  typedef logic signed [W_W-1:0]   wgt_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAYER,
    ST_XFER,
    ST_FEED,
    ST_FIN
  } nn_state_e;

  // one multiply-accumulate step, operands widened before the product
  function automatic acc_t mac_step(input acc_t acc, input act_t x, input wgt_t w);
    return acc + (acc_t'(x) * acc_t'(w));
  endfunction

  // scale by arithmetic shift and clamp into the activation range
  function automatic act_t sat_act(input acc_t a, input int unsigned sh);
    acc_t s;
    s = a >>> sh;
    if (s > acc_t'(127))       return act_t'(127);
    else if (s < acc_t'(-128)) return act_t'(-128);
    else                       return act_t'(s);
  endfunction
endpackage

// File: rtl/nn_mac_node.sv
module nn_mac_node
  import nn_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  wgt_t              wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  act_t              bus_x,
  input  logic              clr,
  input  logic              mac_en,
  output acc_t              acc_o
);
  wgt_t wmem [DEPTH];
  wgt_t w_cur;

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) wmem[wr_addr] <= wr_data;
  end

  assign w_cur = wmem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_o <= '0;
    else if (clr)    acc_o <= '0;
    else if (mac_en) acc_o <= mac_step(acc_o, bus_x, w_cur);
  end
endmodule

// File: rtl/nn_seq.sv
module nn_seq
  import nn_pkg::*;
#(
  parameter int N_IN    = 16,
  parameter int N_NODES = 8,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  output logic             busy,
  output logic             mac_en,
  output logic             clr,
  output logic             hid_latch,
  output logic             fb_phase,
  output logic             fin,
  output logic [CNT_W-1:0] cnt
);
  nn_state_e st;

  assign busy      = (st != ST_IDLE);
  assign fb_phase  = (st == ST_FEED);
  assign hid_latch = (st == ST_XFER);
  assign fin       = (st == ST_FIN);
  assign mac_en    = ((st == ST_LAYER) && in_valid) || (st == ST_FEED);
  assign clr       = ((st == ST_IDLE) && start) || (st == ST_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st  <= ST_LAYER;
          cnt <= '0;
        end
        ST_LAYER: if (in_valid) begin
          if (cnt == CNT_W'(N_IN - 1)) begin
            st  <= ST_XFER;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_XFER: st <= ST_FEED;
        ST_FEED: begin
          if (cnt == CNT_W'(N_NODES - 1)) begin
            st  <= ST_FIN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FIN: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nn_mac_array.sv
module nn_mac_array
  import nn_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int N_IN    = 16,
  parameter int SHIFT   = 8,
  localparam int DEPTH  = N_IN + N_NODES,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int NODE_W = $clog2(N_NODES),
  localparam int CNT_W  = $clog2(((N_IN > N_NODES) ? N_IN : N_NODES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_we,
  input  logic [NODE_W-1:0] w_node,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [15:0]       w_data,
  input  logic              start,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              done,
  output logic [7:0]        out_data
);
  // named internal events, observed by the bound checker
  logic             busy;
  logic             mac_en;
  logic             clr;
  logic             hid_latch;
  logic             fb_phase;
  logic             fin;
  logic [CNT_W-1:0] cnt;

  logic [ADDR_W-1:0] rd_addr;
  act_t              bus_x;
  act_t              hid [N_NODES];
  acc_t              acc [N_NODES];

  nn_seq #(.N_IN(N_IN), .N_NODES(N_NODES), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .busy      (busy),
    .mac_en    (mac_en),
    .clr       (clr),
    .hid_latch (hid_latch),
    .fb_phase  (fb_phase),
    .fin       (fin),
    .cnt       (cnt)
  );

  // input slots first, feedback slots after them
  assign rd_addr = fb_phase ? (ADDR_W'(N_IN) + ADDR_W'(cnt)) : ADDR_W'(cnt);
  assign bus_x   = fb_phase ? hid[cnt[NODE_W-1:0]] : act_t'(in_data);

  for (genvar n = 0; n < N_NODES; n++) begin : g_node
    nn_mac_node #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_node (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (w_we && (w_node == NODE_W'(n))),
      .wr_addr (w_addr),
      .wr_data (wgt_t'(w_data)),
      .rd_addr (rd_addr),
      .bus_x   (bus_x),
      .clr     (clr),
      .mac_en  (mac_en),
      .acc_o   (acc[n])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hid[n] <= '0;
      else if (hid_latch) hid[n] <= sat_act(acc[n], SHIFT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      out_data <= '0;
    end else begin
      done <= fin;
      if (fin) out_data <= sat_act(acc[0], SHIFT);
    end
  end
endmodule

// File: rtl/nn_mac_array_chk.sv
module nn_mac_array_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic [7:0] out_data,
  input logic       busy,
  input logic       mac_en,
  input logic       hid_latch,
  input logic       fb_phase,
  input logic       fin
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_follows_fin: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fin));

  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(out_data));

  a_r7_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r7_run_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> busy);

  a_r5_feed_accumulates: assert property (@(posedge clk) disable iff (!rst_n)
    fb_phase |-> mac_en);

  a_r4_latch_then_feed: assert property (@(posedge clk) disable iff (!rst_n)
    hid_latch |=> fb_phase);
endmodule

bind nn_mac_array nn_mac_array_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .out_data  (out_data),
  .busy      (busy),
  .mac_en    (mac_en),
  .hid_latch (hid_latch),
  .fb_phase  (fb_phase),
  .fin       (fin)
);

// File: tb/nn_mac_array_bench.sv
`timescale 1ns/1ps
module nn_mac_array_bench;
  localparam int NN   = 8;
  localparam int NI   = 16;
  localparam int SH   = 8;
  localparam int DEP  = NI + NN;
  localparam int AW   = $clog2(DEP);
  localparam int NW   = $clog2(NN);
  localparam int LAT  = NN + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          w_we = 1'b0;
  logic [NW-1:0] w_node = '0;
  logic [AW-1:0] w_addr = '0;
  logic [15:0]   w_data = '0;
  logic          start = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          done;
  logic [7:0]    out_data;

  int total = 0;
  int bad = 0;
  int wm [NN][DEP];
  int xin [NI];
  int exp_q [$];
  int last_exp = 0;

  always #2 clk = ~clk;

  nn_mac_array #(.N_NODES(NN), .N_IN(NI), .SHIFT(SH)) u_nn_mac_array (
    .clk(clk), .rst_n(rst_n), .w_we(w_we), .w_node(w_node), .w_addr(w_addr),
    .w_data(w_data), .start(start), .in_valid(in_valid), .in_data(in_data),
    .done(done), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // floor of v / 2^SH, then clamp to the activation range
  function automatic int squash(input longint v);
    longint q;
    q = v / (64'sd1 << SH);
    if ((q * (64'sd1 << SH)) > v) q = q - 1;
    if (q > 127) return 127;
    if (q < -128) return -128;
    return int'(q);
  endfunction

  function automatic int model();
    int h [NN];
    longint s;
    for (int n = 0; n < NN; n++) begin
      s = 0;
      for (int k = 0; k < NI; k++) s += longint'(xin[k]) * longint'(wm[n][k]);
      h[n] = squash(s);
    end
    s = 0;
    for (int k = 0; k < NN; k++) s += longint'(h[k]) * longint'(wm[0][NI + k]);
    return squash(s);
  endfunction

  task automatic put_w(input int n, input int a, input int v);
    @(negedge clk);
    w_we = 1'b1; w_node = NW'(n); w_addr = AW'(a); w_data = 16'(v);
    wm[n][a] = v;
    @(negedge clk);
    w_we = 1'b0;
  endtask

  // driver: pushes the expected result, runs the stream, measures R9 latency
  task automatic run(input bit gaps, input bit poke, input int idle_beats);
    int lat;
    exp_q.push_back(model());
    for (int i = 0; i < idle_beats; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(i * 37 + 11);
    end
    @(negedge clk);
    in_valid = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < NI; k++) begin
      if (gaps && (k % 3 == 1)) begin
        in_valid = 1'b0; in_data = 8'hA5;
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = 8'(xin[k]);
      start = poke && (k == 4);
      if (k != NI - 1) @(negedge clk);
    end
    @(posedge clk);
    lat = 0;
    while (lat < 60) begin
      @(negedge clk);
      in_valid = 1'b0; start = 1'b0;
      if (done) break;
      if (poke && lat == 3) start = 1'b1;
      @(posedge clk);
      lat++;
    end
    check(lat == LAT, "R9 latency", lat, LAT);
    repeat (6) @(negedge clk);
  endtask

  // monitor: pops expected results as done strobes arrive
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6/R7 unexpected done", 1, 0);
        end else begin
          last_exp = exp_q.pop_front();
          check($signed(out_data) == last_exp, "R5/R3/R4 result", $signed(out_data), last_exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R9 watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int x;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(out_data == 8'd0, "R1 out after reset", int'(out_data), 0);
    rst_n = 1'b1;

    // R2/R3/R5: diagonal unity weights, unity output weights
    for (int n = 0; n < NN; n++)
      for (int a = 0; a < DEP; a++)
        put_w(n, a, (a == n || (n == 0 && a >= NI)) ? 256 : 0);
    for (int k = 0; k < NI; k++) xin[k] = k - 5;
    run(1'b0, 1'b0, 0);

    // R3/R4: random signed weights and inputs
    for (int n = 0; n < NN; n++)
      for (int a = 0; a < DEP; a++) put_w(n, a, int'($urandom_range(1200)) - 600);
    for (int k = 0; k < NI; k++) xin[k] = int'($urandom_range(255)) - 128;
    run(1'b0, 1'b0, 0);

    // R3: gapped beats, new random inputs
    for (int k = 0; k < NI; k++) xin[k] = int'($urandom_range(255)) - 128;
    run(1'b1, 1'b0, 0);

    // R4/R5: hidden clamp high, output clamp low
    for (int n = 0; n < NN; n++)
      for (int a = 0; a < DEP; a++) put_w(n, a, (a < NI) ? 32767 : -32768);
    for (int k = 0; k < NI; k++) xin[k] = 127;
    run(1'b0, 1'b0, 0);

    // R4/R5: hidden clamp low, output clamp high
    for (int k = 0; k < NI; k++) xin[k] = -128;
    run(1'b0, 1'b0, 0);

    // R7: stray start pulses during input and feedback phases
    for (int n = 0; n < NN; n++)
      for (int a = 0; a < DEP; a++) put_w(n, a, int'($urandom_range(800)) - 400);
    for (int k = 0; k < NI; k++) xin[k] = int'($urandom_range(255)) - 128;
    run(1'b0, 1'b1, 0);
    check(exp_q.size() == 0, "R7 no extra done", exp_q.size(), 0);

    // R8: beats presented while idle are ignored
    for (int k = 0; k < NI; k++) xin[k] = (k * 13) % 200 - 100;
    run(1'b0, 1'b0, 5);

    // R2: a single feedback weight rewrite on node 0 alters the result
    put_w(0, NI + 3, -20000);
    run(1'b0, 1'b0, 0);

    // R6: output holds after the strobe
    repeat (10) @(negedge clk);
    x = $signed(out_data);
    check(x == last_exp, "R6 out holds", x, last_exp);
    check(done == 1'b0, "R6 done low while idle", int'(done), 0);
    check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule